// File: doc/BRIEF.md
# Per-Master Address Decoder with Boot Remap

This block turns a master's bus address into a slave choice. Each master on the on-chip bus has its own copy, so each master can see a different memory map. The top four address bits pick one of sixteen 256 MB regions:

- Eight consecutive regions go to the external memory controller, and each one drives its own active-low chip select.
- The top region goes to the peripheral bridge.
- Region zero is decoded again on 1 MB windows: a ROM window, an SRAM window, and a window at address zero whose contents depend on boot mode and remap.
- The remaining regions, and the empty windows in region zero, select nothing. The master then receives a two-cycle error response.

Two small state machines hold the state. The zero-map machine has four states:

- `ZM_SAMPLE`: the first cycle after reset. The window at zero follows the live boot pin.
- `ZM_INT_BOOT`: the latched pin was low, so the window shows ROM.
- `ZM_EXT_BOOT`: the latched pin was high, so the window shows external chip select 0.
- `ZM_REMAPPED`: the window shows SRAM. This state is sticky until reset.

Transitions: `SAMPLE→INT_BOOT/EXT_BOOT` occurs on the first clock edge and follows the pin. `any→REMAPPED` occurs on a remap write.

The error machine has three states: `ER_IDLE`, `ER_FIRST` and `ER_SECOND`. Transitions: `IDLE→FIRST` on a bad access. `FIRST→SECOND` always. `SECOND→FIRST` on another bad access. `SECOND→IDLE` otherwise.

Top module: `addr_map_decoder`

## Requirements
- R1: In regions 1 to 8 (addr[31:28]), a valid access sets slv_sel bit 2 (external controller) and drives ext_cs_n[region-1] low, with all other chip selects high. slv_offs carries addr[27:0].
- R2: In region 15, a valid access sets slv_sel bit 3 (peripheral bridge) and slv_offs carries addr[27:0]. No chip select is driven low.
- R3: In regions 9 to 14, a valid access sets no slv_sel bit, keeps all chip selects high, keeps slv_offs at zero, and starts an error response.
- R4: In region 0, window addr[27:20]=1 sets slv_sel bit 0 (ROM) with slv_offs = addr[14:0]. Window 2 sets slv_sel bit 1 (SRAM) with slv_offs = addr[16:0]. Both windows alias on those sizes.
- R5: In region 0, windows 3 to 255 select nothing and start an error response.
- R6: When addr_valid is low, slv_sel is zero, all chip selects are high, slv_offs is zero, and no error response starts.
- R7: An error response starts on the clock edge that samples the bad access. In the cycle after that edge, rsp_ready=0 and rsp_err=1. In the cycle after that, rsp_ready=1 and rsp_err=1. The outputs then return to ready=1 and err=0, unless the access sampled in that second cycle is also bad, in which case a new response starts.
- R8: On a processor instance (IS_CPU=1) with no remap, window 0 of region 0 shows the ROM (slv_sel bit 0, offs addr[14:0]) when the latched boot_ext is 0. When the latched boot_ext is 1, it shows the external device on chip select 0 (slv_sel bit 2, ext_cs_n[0] low, offs addr[19:0]).
- R9: boot_ext is latched on the first clock edge after rst_n rises. Before that edge, window 0 follows the live pin. After that edge, changes on the pin have no effect.
- R10: A cycle with remap_set high makes window 0 show SRAM (slv_sel bit 1, offs addr[16:0]) from the next cycle on, whatever the boot mode. Only rst_n clears this.
- R11: On a non-processor instance (IS_CPU=0), window 0 always shows SRAM, whatever boot_ext and remap_set do.
- R12: While rst_n is low, rsp_ready=1 and rsp_err=0, even when bad accesses are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_ext | input | 1 | Boot strap: 1 = boot from external device |
| remap_set | input | 1 | Remap control write strobe |
| addr_valid | input | 1 | Transfer valid |
| addr | input | 32 | Transfer address |
| slv_sel | output | 4 | One-hot slave select: 0 ROM, 1 SRAM, 2 external, 3 bridge |
| ext_cs_n | output | 8 | Active-low external chip selects |
| slv_offs | output | 28 | Address offset passed to the selected slave |
| rsp_ready | output | 1 | Response ready (low only in the first error cycle) |
| rsp_err | output | 1 | Error response flag |

## Verification
Slave selects, chip selects and offsets are combinational. They are due in the same cycle the address is presented, so the bench drives on the falling edge and compares shortly before the next rising edge. The error response, the boot latch and the remap take effect one rising edge later. The bench's reference model advances its own state on that same edge, so each comparison made before the following edge already reflects the access sampled. Every cycle compares both a processor instance and a non-processor instance against the model.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;

    localparam int N_SLV      = 4;
    localparam int SLV_ROM    = 0;
    localparam int SLV_SRAM   = 1;
    localparam int SLV_EBI    = 2;
    localparam int SLV_BRIDGE = 3;

    typedef enum logic [1:0] {
        RK_INTERNAL,
        RK_EXTERNAL,
        RK_BRIDGE,
        RK_UNUSED
    } region_kind_t;

    typedef enum logic [1:0] {
        WK_ROM,
        WK_SRAM,
        WK_EXT0,
        WK_HOLE
    } win_kind_t;

    typedef enum logic [1:0] {
        ZT_ROM,
        ZT_SRAM,
        ZT_EXT0
    } zero_tgt_t;

    typedef enum logic [1:0] {
        ZM_SAMPLE,
        ZM_INT_BOOT,
        ZM_EXT_BOOT,
        ZM_REMAPPED
    } zm_state_t;

    typedef enum logic [1:0] {
        ER_IDLE,
        ER_FIRST,
        ER_SECOND
    } er_state_t;

endpackage

// File: rtl/region_decoder.sv
module region_decoder
    import addr_map_pkg::*;
#(
    parameter int REGION_BITS      = 4,
    parameter int N_EXT_CS         = 8,
    parameter int INT_REGION       = 0,
    parameter int EXT_FIRST_REGION = 1,
    parameter int PERIPH_REGION    = 15,
    localparam int CS_IW           = (N_EXT_CS > 1) ? $clog2(N_EXT_CS) : 1
) (
    input  logic [REGION_BITS-1:0] region,
    output region_kind_t           kind,
    output logic [CS_IW-1:0]       cs_idx
);

    localparam logic [REGION_BITS-1:0] INT_R  = REGION_BITS'(INT_REGION);
    localparam logic [REGION_BITS-1:0] EXT_LO = REGION_BITS'(EXT_FIRST_REGION);
    localparam logic [REGION_BITS-1:0] EXT_HI = REGION_BITS'(EXT_FIRST_REGION + N_EXT_CS - 1);
    localparam logic [REGION_BITS-1:0] PER_R  = REGION_BITS'(PERIPH_REGION);

    logic                   in_ext;
    logic [REGION_BITS-1:0] rel;

    assign in_ext = (region >= EXT_LO) && (region <= EXT_HI);
    assign rel    = region - EXT_LO;

    always_comb begin
        cs_idx = '0;
        if (region == INT_R) begin
            kind = RK_INTERNAL;
        end else if (in_ext) begin
            kind   = RK_EXTERNAL;
            cs_idx = CS_IW'(rel);
        end else if (region == PER_R) begin
            kind = RK_BRIDGE;
        end else begin
            kind = RK_UNUSED;
        end
    end

endmodule

// File: rtl/internal_window_decoder.sv
module internal_window_decoder
    import addr_map_pkg::*;
#(
    parameter int OFFS_W   = 28,
    parameter int WIN_BITS = 20,
    parameter int ROM_AW   = 15,
    parameter int SRAM_AW  = 17,
    parameter int ROM_WIN  = 1,
    parameter int SRAM_WIN = 2,
    localparam int SEL_W   = OFFS_W - WIN_BITS
) (
    input  logic [SEL_W-1:0]    win,
    input  logic [WIN_BITS-1:0] low,
    input  zero_tgt_t           zero_tgt,
    output win_kind_t           kind,
    output logic [OFFS_W-1:0]   offs
);

    localparam logic [SEL_W-1:0] ROM_W  = SEL_W'(ROM_WIN);
    localparam logic [SEL_W-1:0] SRAM_W = SEL_W'(SRAM_WIN);

    logic [OFFS_W-1:0] rom_offs;
    logic [OFFS_W-1:0] sram_offs;
    logic [OFFS_W-1:0] ext_offs;

    assign rom_offs  = OFFS_W'(low[ROM_AW-1:0]);
    assign sram_offs = OFFS_W'(low[SRAM_AW-1:0]);
    assign ext_offs  = OFFS_W'(low);

    always_comb begin
        kind = WK_HOLE;
        offs = '0;
        if (win == '0) begin
            unique case (zero_tgt)
                ZT_ROM:  begin kind = WK_ROM;  offs = rom_offs;  end
                ZT_SRAM: begin kind = WK_SRAM; offs = sram_offs; end
                ZT_EXT0: begin kind = WK_EXT0; offs = ext_offs;  end
                default: begin kind = WK_HOLE; offs = '0;        end
            endcase
        end else if (win == ROM_W) begin
            kind = WK_ROM;
            offs = rom_offs;
        end else if (win == SRAM_W) begin
            kind = WK_SRAM;
            offs = sram_offs;
        end
    end

endmodule

// File: rtl/zero_map_fsm.sv
module zero_map_fsm
    import addr_map_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      boot_ext,
    input  logic      remap_set,
    output zero_tgt_t zero_tgt,
    output logic      remapped
);

    zm_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ZM_SAMPLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ZM_SAMPLE: begin
                if (remap_set)     state_d = ZM_REMAPPED;
                else if (boot_ext) state_d = ZM_EXT_BOOT;
                else               state_d = ZM_INT_BOOT;
            end
            ZM_INT_BOOT: if (remap_set) state_d = ZM_REMAPPED;
            ZM_EXT_BOOT: if (remap_set) state_d = ZM_REMAPPED;
            ZM_REMAPPED: state_d = ZM_REMAPPED;
            default:     state_d = ZM_SAMPLE;
        endcase
    end

    always_comb begin
        remapped = 1'b0;
        unique case (state_q)
            ZM_SAMPLE:   zero_tgt = boot_ext ? ZT_EXT0 : ZT_ROM;
            ZM_INT_BOOT: zero_tgt = ZT_ROM;
            ZM_EXT_BOOT: zero_tgt = ZT_EXT0;
            ZM_REMAPPED: begin
                zero_tgt = ZT_SRAM;
                remapped = 1'b1;
            end
            default:     zero_tgt = ZT_ROM;
        endcase
    end

endmodule

// File: rtl/abort_resp_fsm.sv
module abort_resp_fsm
    import addr_map_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bad_access,
    output logic rsp_ready,
    output logic rsp_err
);

    er_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ER_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ER_IDLE:   if (bad_access) state_d = ER_FIRST;
            ER_FIRST:  state_d = ER_SECOND;
            ER_SECOND: state_d = bad_access ? ER_FIRST : ER_IDLE;
            default:   state_d = ER_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ER_IDLE:   begin rsp_ready = 1'b1; rsp_err = 1'b0; end
            ER_FIRST:  begin rsp_ready = 1'b0; rsp_err = 1'b1; end
            ER_SECOND: begin rsp_ready = 1'b1; rsp_err = 1'b1; end
            default:   begin rsp_ready = 1'b1; rsp_err = 1'b0; end
        endcase
    end

endmodule

// File: rtl/addr_map_decoder.sv
module addr_map_decoder
    import addr_map_pkg::*;
#(
    parameter int ADDR_W           = 32,
    parameter int REGION_BITS      = 4,
    parameter int N_EXT_CS         = 8,
    parameter int INT_REGION       = 0,
    parameter int EXT_FIRST_REGION = 1,
    parameter int PERIPH_REGION    = 15,
    parameter int WIN_BITS         = 20,
    parameter int ROM_AW           = 15,
    parameter int SRAM_AW          = 17,
    parameter int ROM_WIN          = 1,
    parameter int SRAM_WIN         = 2,
    parameter bit IS_CPU           = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          boot_ext,
    input  logic                          remap_set,
    input  logic                          addr_valid,
    input  logic [ADDR_W-1:0]             addr,
    output logic [N_SLV-1:0]              slv_sel,
    output logic [N_EXT_CS-1:0]           ext_cs_n,
    output logic [ADDR_W-REGION_BITS-1:0] slv_offs,
    output logic                          rsp_ready,
    output logic                          rsp_err
);

    localparam int OFFS_W = ADDR_W - REGION_BITS;
    localparam int SEL_W  = OFFS_W - WIN_BITS;
    localparam int CS_IW  = (N_EXT_CS > 1) ? $clog2(N_EXT_CS) : 1;

    region_kind_t         r_kind;
    logic [CS_IW-1:0]     r_cs_idx;
    win_kind_t            w_kind;
    logic [OFFS_W-1:0]    w_offs;
    zero_tgt_t            zero_tgt;
    logic                 remapped_q;
    logic                 bad_access;
    logic                 ebi_hit;
    logic [CS_IW-1:0]     cs_idx;

    region_decoder #(
        .REGION_BITS      (REGION_BITS),
        .N_EXT_CS         (N_EXT_CS),
        .INT_REGION       (INT_REGION),
        .EXT_FIRST_REGION (EXT_FIRST_REGION),
        .PERIPH_REGION    (PERIPH_REGION)
    ) u_region (
        .region (addr[ADDR_W-1 -: REGION_BITS]),
        .kind   (r_kind),
        .cs_idx (r_cs_idx)
    );

    internal_window_decoder #(
        .OFFS_W   (OFFS_W),
        .WIN_BITS (WIN_BITS),
        .ROM_AW   (ROM_AW),
        .SRAM_AW  (SRAM_AW),
        .ROM_WIN  (ROM_WIN),
        .SRAM_WIN (SRAM_WIN)
    ) u_window (
        .win      (addr[OFFS_W-1 -: SEL_W]),
        .low      (addr[WIN_BITS-1:0]),
        .zero_tgt (zero_tgt),
        .kind     (w_kind),
        .offs     (w_offs)
    );

    generate
        if (IS_CPU) begin : g_cpu_map
            zero_map_fsm u_zero (
                .clk       (clk),
                .rst_n     (rst_n),
                .boot_ext  (boot_ext),
                .remap_set (remap_set),
                .zero_tgt  (zero_tgt),
                .remapped  (remapped_q)
            );
        end else begin : g_fixed_map
            logic unused_straps;
            assign unused_straps = boot_ext ^ remap_set;
            assign zero_tgt      = ZT_SRAM;
            assign remapped_q    = 1'b0;
        end
    endgenerate

    always_comb begin
        slv_sel    = '0;
        slv_offs   = '0;
        ebi_hit    = 1'b0;
        cs_idx     = '0;
        bad_access = 1'b0;
        if (addr_valid) begin
            unique case (r_kind)
                RK_EXTERNAL: begin
                    slv_sel[SLV_EBI] = 1'b1;
                    ebi_hit          = 1'b1;
                    cs_idx           = r_cs_idx;
                    slv_offs         = addr[OFFS_W-1:0];
                end
                RK_BRIDGE: begin
                    slv_sel[SLV_BRIDGE] = 1'b1;
                    slv_offs            = addr[OFFS_W-1:0];
                end
                RK_INTERNAL: begin
                    unique case (w_kind)
                        WK_ROM: begin
                            slv_sel[SLV_ROM] = 1'b1;
                            slv_offs         = w_offs;
                        end
                        WK_SRAM: begin
                            slv_sel[SLV_SRAM] = 1'b1;
                            slv_offs          = w_offs;
                        end
                        WK_EXT0: begin
                            slv_sel[SLV_EBI] = 1'b1;
                            ebi_hit          = 1'b1;
                            slv_offs         = w_offs;
                        end
                        default: bad_access = 1'b1;
                    endcase
                end
                default: bad_access = 1'b1;
            endcase
        end
    end

    genvar g;
    generate
        for (g = 0; g < N_EXT_CS; g++) begin : g_cs
            assign ext_cs_n[g] = !(ebi_hit && (cs_idx == CS_IW'(g)));
        end
    endgenerate

    abort_resp_fsm u_abort (
        .clk        (clk),
        .rst_n      (rst_n),
        .bad_access (bad_access),
        .rsp_ready  (rsp_ready),
        .rsp_err    (rsp_err)
    );

endmodule

// File: rtl/addr_map_decoder_checker.sv
module addr_map_decoder_checker #(
    parameter int ADDR_W           = 32,
    parameter int REGION_BITS      = 4,
    parameter int N_EXT_CS         = 8,
    parameter int EXT_FIRST_REGION = 1,
    parameter int PERIPH_REGION    = 15,
    parameter int WIN_BITS         = 20
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          addr_valid,
    input logic [ADDR_W-1:0]             addr,
    input logic [3:0]                    slv_sel,
    input logic [N_EXT_CS-1:0]           ext_cs_n,
    input logic [ADDR_W-REGION_BITS-1:0] slv_offs,
    input logic                          rsp_ready,
    input logic                          rsp_err,
    input logic                          remapped
);

    localparam int OFFS_W = ADDR_W - REGION_BITS;

    int  region_i;
    logic unused_region;
    logic zero_win;

    assign region_i      = int'(addr[ADDR_W-1 -: REGION_BITS]);
    assign unused_region = (region_i >= EXT_FIRST_REGION + N_EXT_CS) && (region_i < PERIPH_REGION);
    assign zero_win      = (addr[ADDR_W-1:WIN_BITS] == '0);

    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> $onehot0(slv_sel));

    assert_cs_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        slv_sel[2] |-> ($countones(~ext_cs_n) == 1));

    assert_cs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !slv_sel[2] |-> (&ext_cs_n));

    assert_unused_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && unused_region) |-> (slv_sel == '0 && slv_offs == '0));

    assert_err_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && unused_region && rsp_ready) |=> (!rsp_ready && rsp_err));

    assert_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> (slv_sel == '0 && (&ext_cs_n) && slv_offs == OFFS_W'(0)));

    assert_err_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ready |=> (rsp_ready && rsp_err));

    assert_ready_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ready |-> rsp_err);

    assert_remap_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        remapped |=> remapped);

    assert_remap_sram_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (remapped && addr_valid && zero_win) |-> (slv_sel == 4'b0010));

endmodule

bind addr_map_decoder addr_map_decoder_checker #(
    .ADDR_W           (ADDR_W),
    .REGION_BITS      (REGION_BITS),
    .N_EXT_CS         (N_EXT_CS),
    .EXT_FIRST_REGION (EXT_FIRST_REGION),
    .PERIPH_REGION    (PERIPH_REGION),
    .WIN_BITS         (WIN_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_valid (addr_valid),
    .addr       (addr),
    .slv_sel    (slv_sel),
    .ext_cs_n   (ext_cs_n),
    .slv_offs   (slv_offs),
    .rsp_ready  (rsp_ready),
    .rsp_err    (rsp_err),
    .remapped   (remapped_q)
);

// File: tb/addr_map_decoder_tb.sv
`timescale 1ns/1ps
module addr_map_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_ext = 1'b1;
    logic        remap_set = 1'b0;
    logic        addr_valid = 1'b0;
    logic [31:0] addr = '0;

    logic [3:0]  sel_c, sel_d;
    logic [7:0]  csn_c, csn_d;
    logic [27:0] offs_c, offs_d;
    logic        rdy_c, rdy_d, err_c, err_d;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    addr_map_decoder #(.IS_CPU(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .boot_ext(boot_ext), .remap_set(remap_set),
        .addr_valid(addr_valid), .addr(addr),
        .slv_sel(sel_c), .ext_cs_n(csn_c), .slv_offs(offs_c),
        .rsp_ready(rdy_c), .rsp_err(err_c)
    );

    addr_map_decoder #(.IS_CPU(1'b0)) u_dut_dma (
        .clk(clk), .rst_n(rst_n), .boot_ext(boot_ext), .remap_set(remap_set),
        .addr_valid(addr_valid), .addr(addr),
        .slv_sel(sel_d), .ext_cs_n(csn_d), .slv_offs(offs_d),
        .rsp_ready(rdy_d), .rsp_err(err_d)
    );

    // reference model state
    int m_err = 0;        // 0 none, 1 first error cycle, 2 second error cycle
    bit m_sampled = 1'b0;
    bit m_boot = 1'b0;
    bit m_remap = 1'b0;

    function automatic bit is_bad(logic [31:0] a, logic v);
        int r = int'(a[31:28]);
        int w = int'(a[27:20]);
        return v && ((r >= 9 && r <= 14) || (r == 0 && w > 2));
    endfunction

    function automatic logic [41:0] expect_out(logic [31:0] a, logic v, bit cpu);
        logic [3:0]  s = '0;
        logic [7:0]  c = 8'hFF;
        logic [27:0] o = '0;
        int r = int'(a[31:28]);
        int w = int'(a[27:20]);
        int tgt;  // 0 rom, 1 sram, 2 ext0, 3 none
        bit ext_boot;
        if (v) begin
            if (r >= 1 && r <= 8) begin
                s = 4'b0100; c[r-1] = 1'b0; o = a[27:0];
            end else if (r == 15) begin
                s = 4'b1000; o = a[27:0];
            end else if (r == 0) begin
                tgt = 3;
                if (w == 1) tgt = 0;
                else if (w == 2) tgt = 1;
                else if (w == 0) begin
                    if (!cpu || m_remap) tgt = 1;
                    else begin
                        ext_boot = m_sampled ? m_boot : boot_ext;
                        tgt = ext_boot ? 2 : 0;
                    end
                end
                case (tgt)
                    0: begin s = 4'b0001; o = {13'd0, a[14:0]}; end
                    1: begin s = 4'b0010; o = {11'd0, a[16:0]}; end
                    2: begin s = 4'b0100; c[0] = 1'b0; o = {8'd0, a[19:0]}; end
                    default: ;
                endcase
            end
        end
        return {s, c, o, (m_err != 1), (m_err != 0)};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_err     <= 0;
            m_sampled <= 1'b0;
            m_boot    <= 1'b0;
            m_remap   <= 1'b0;
        end else begin
            if (!m_sampled) begin
                m_sampled <= 1'b1;
                m_boot    <= boot_ext;
            end
            if (remap_set) m_remap <= 1'b1;
            if (m_err == 1) m_err <= 2;
            else m_err <= is_bad(addr, addr_valid) ? 1 : 0;
        end
    end

    logic nxt_rst_n = 1'b0;
    logic nxt_boot  = 1'b1;

    task automatic compare(string tag, logic [41:0] act, logic [41:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (sel,cs_n,offs,ready,err)", tag, act, exp);
        end
    endtask

    task automatic step(string tag, logic [31:0] a, logic v, logic rs);
        string dtag;
        @(negedge clk);
        rst_n      = nxt_rst_n;
        boot_ext   = nxt_boot;
        addr       = a;
        addr_valid = v;
        remap_set  = rs;
        #1;
        dtag = (v && a[31:20] == 12'h000) ? "R11" : tag;
        compare(tag,  {sel_c, csn_c, offs_c, rdy_c, err_c}, expect_out(a, v, 1'b1));
        compare(dtag, {sel_d, csn_d, offs_d, rdy_d, err_d}, expect_out(a, v, 1'b0));
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R12: reset state, bad access ignored during reset
        step("R12", 32'h0000_0000, 1'b0, 1'b0);
        step("R12", 32'hA000_0000, 1'b1, 1'b0);
        step("R12", 32'hA000_0000, 1'b1, 1'b0);
        // R9: release with pin high; first cycle follows live pin
        nxt_rst_n = 1'b1;
        step("R9", 32'h0000_0040, 1'b1, 1'b0);
        nxt_boot = 1'b0;
        step("R9", 32'h0001_2344, 1'b1, 1'b0);
        step("R8", 32'h000F_FFF0, 1'b1, 1'b0);
        nxt_boot = 1'b1;
        // R1 / R2 / R3 over every region
        for (int r = 1; r < 16; r++) begin
            string t;
            if (r <= 8) t = "R1";
            else if (r == 15) t = "R2";
            else t = "R3";
            step(t, {r[3:0], 28'h0AB_CDE4}, 1'b1, 1'b0);
            step("R7", 32'h0000_0000, 1'b0, 1'b0);
            step("R7", 32'h0000_0000, 1'b0, 1'b0);
        end
        // R4 aliasing
        step("R4", 32'h0010_8004, 1'b1, 1'b0);
        step("R4", 32'h001F_7FFC, 1'b1, 1'b0);
        step("R4", 32'h0022_0010, 1'b1, 1'b0);
        step("R4", 32'h002F_FFF8, 1'b1, 1'b0);
        // R5 holes, back to back for R7
        step("R5", 32'h0030_0000, 1'b1, 1'b0);
        step("R7", 32'h0FF0_0000, 1'b1, 1'b0);
        step("R7", 32'h0FF0_0000, 1'b1, 1'b0);
        step("R7", 32'h1000_0000, 1'b1, 1'b0);
        step("R7", 32'h1000_0000, 1'b1, 1'b0);
        // R6 no valid with otherwise bad/good addresses
        step("R6", 32'hC000_0000, 1'b0, 1'b0);
        step("R6", 32'h3000_0010, 1'b0, 1'b0);
        step("R6", 32'h0000_0010, 1'b0, 1'b0);
        // R10 remap
        step("R10", 32'h0000_0100, 1'b1, 1'b1);
        step("R10", 32'h0000_0100, 1'b1, 1'b0);
        nxt_boot = 1'b0;
        step("R10", 32'h000A_BCDC, 1'b1, 1'b0);
        step("R10", 32'h0011_0000, 1'b1, 1'b0);
        // second reset, internal boot
        nxt_rst_n = 1'b0;
        step("R12", 32'hB000_0000, 1'b1, 1'b0);
        step("R12", 32'h0000_0000, 1'b1, 1'b0);
        nxt_rst_n = 1'b1;
        step("R9", 32'h0000_0020, 1'b1, 1'b0);
        nxt_boot = 1'b1;
        step("R8", 32'h0000_8020, 1'b1, 1'b0);
        step("R9", 32'h0004_0000, 1'b1, 1'b0);
        step("R10", 32'h0000_0000, 1'b0, 1'b1);
        step("R10", 32'h0001_0004, 1'b1, 1'b0);
        step("R1", 32'h8FFF_FFFC, 1'b1, 1'b0);
        step("R2", 32'hF000_0004, 1'b1, 1'b0);
        step("R6", 32'h0000_0000, 1'b0, 1'b0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule